// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the byte-wide arithmetic and logic unit of a small accumulator machine. Each cycle it takes an operation code, the accumulator byte, a second operand byte and a single bit operand. When the write enable is high, it stores a result byte, a second result byte and the carry, auxiliary-carry and overflow flags in registers. The flag registers are the machine's current flags. Every operation that consumes a carry or an auxiliary carry reads it from these registers, so a sequence of operations chains through the flags with no help from outside.

Operand fetch, instruction decode and memory access belong to the surrounding core. The core presents the operands, decodes an operation code and raises the write enable for one cycle per executed operation. It then takes the result and the second result from the outputs one clock edge later. The second result carries the operand byte back out, so that low-nibble exchange can return both halves of the exchange.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on op_i: 0 add, 1 add with carry, 2 subtract with borrow, 3 AND, 4 OR, 5 XOR, 6 increment, 7 decrement, 8 complement, 9 clear, 10 rotate left, 11 rotate right, 12 rotate left through carry, 13 rotate right through carry, 14 nibble swap, 15 low-nibble exchange, 16 decimal adjust, 17 carry AND bit, 18 carry OR bit, 19 clear carry, 20 set carry, 21 complement carry. When we_i is high at a rising clock edge, result_o, opnd_o and the flags show that operation's outcome after that edge. When we_i is low, all outputs hold their values.
- R2: Add computes acc_i+opnd_i and ignores the current carry. Add with carry computes acc_i+opnd_i+cy. Both set cy_o to the carry out of bit 7 and ac_o to the carry out of bit 3. Both set ov_o when the two operands have the same sign and the result has the other sign.
- R3: Subtract with borrow computes acc_i-opnd_i-cy modulo 256. It sets cy_o on a borrow out of bit 7 and ac_o on a borrow into bit 3. It sets ov_o when the signed difference falls outside -128..127.
- R4: Increment and decrement of acc_i wrap modulo 256 (0xFF+1=0x00, 0x00-1=0xFF) and leave all three flags unchanged.
- R5: AND, OR and XOR of acc_i with opnd_i, complement of acc_i and clear (result 0x00) leave all three flags unchanged.
- R6: Rotate left and rotate right of acc_i by one bit move the end bit around to the other end and leave all three flags unchanged.
- R7: Rotate left through carry gives {acc_i[6:0], cy} and loads acc_i[7] into cy_o. Rotate right through carry gives {cy, acc_i[7:1]} and loads acc_i[0] into cy_o. AC and OV are unchanged.
- R8: Nibble swap gives {acc_i[3:0], acc_i[7:4]} and leaves the flags unchanged.
- R9: Low-nibble exchange gives result_o = {acc_i[7:4], opnd_i[3:0]} and opnd_o = {opnd_i[7:4], acc_i[3:0]}. Every other operation passes opnd_i to opnd_o unchanged.
- R10: Decimal adjust adds 0x06 when acc_i[3:0] > 9 or ac is set. It then adds 0x60 when the upper nibble of that sum is greater than 9, when the first step carried out, or when cy is set. cy_o is the old cy ORed with any carry out of bit 7, so a set carry is never cleared. AC and OV are unchanged.
- R11: The carry-bit operations set cy_o to cy AND bit_i, cy OR bit_i, 0, 1 or NOT cy. They leave ac_o and ov_o unchanged, and result_o takes acc_i.
- R12: While rst_ni is low, result_o, opnd_o, cy_o, ac_o and ov_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Execute and store the selected operation |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand byte |
| bit_i | input | 1 | Bit operand for the carry AND and carry OR operations |
| result_o | output | 8 | Registered result byte |
| opnd_o | output | 8 | Registered second result (operand byte after the operation) |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |
| ov_o | output | 1 | Overflow flag |

## Verification
The bench targets the decimal adjust cases where the correction depends on stored flags rather than on the digits alone. One case is 0x99+0x99, which leaves 0x32 with carry and auxiliary carry set and must become 0x98. Another is 0xA0, which must become 0x00 and set the carry. A design that tests only the digits, or that clears a carry already set, returns the wrong byte or drops the carry. Sign-overflow cases are also covered: 0x7F+1, 0x80-1 and 0-1. An overflow rule built from the carry alone would flag the wrong ones. The bench also checks that add ignores a set carry while add with carry uses it. Further checks cover the through-carry rotates, whose new bit must come from the old carry, and the exchange of only the low nibbles in both directions. Wrap-around increment and decrement must leave the flags as they were. The last checks confirm that a low write enable freezes every output.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned NIB  = DW / 2;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_AND  = 5'd3,
    OP_OR   = 5'd4,  OP_XOR  = 5'd5,  OP_INC  = 5'd6,  OP_DEC  = 5'd7,
    OP_CPL  = 5'd8,  OP_CLR  = 5'd9,  OP_RL   = 5'd10, OP_RR   = 5'd11,
    OP_RLC  = 5'd12, OP_RRC  = 5'd13, OP_SWAP = 5'd14, OP_XCHD = 5'd15,
    OP_DA   = 5'd16, OP_CAND = 5'd17, OP_COR  = 5'd18, OP_CCLR = 5'd19,
    OP_CSET = 5'd20, OP_CCPL = 5'd21
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o
);
  logic [DW:0]  full;
  logic [NIB:0] low;
  logic [DW:0]  cin_w;
  logic [NIB:0] cin_n;

  assign cin_w = {{DW{1'b0}}, cin_i};
  assign cin_n = {{NIB{1'b0}}, cin_i};

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - cin_w;
      low  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - cin_n;
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + cin_w;
      low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + cin_n;
    end
  end

  assign res_o = full[DW-1:0];
  assign cy_o  = full[DW];
  assign ac_o  = low[NIB];
  // sign rule: operand signs agree (add) or differ (sub), result sign flips
  assign ov_o  = ((a_i[DW-1] ^ b_i[DW-1]) == sub_i) && (res_o[DW-1] != a_i[DW-1]);
endmodule

// File: rtl/acc_alu_dadj.sv
module acc_alu_dadj
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);
  localparam logic [NIB-1:0] DIG_MAX = NIB'(9);
  localparam logic [DW:0]    FIX_LO  = (DW+1)'(6);
  localparam logic [DW:0]    FIX_HI  = FIX_LO << NIB;

  logic [DW:0] step1;
  logic [DW:0] step2;
  logic        fix_lo;
  logic        fix_hi;

  assign fix_lo = (a_i[NIB-1:0] > DIG_MAX) | ac_i;
  assign step1  = {1'b0, a_i} + (fix_lo ? FIX_LO : '0);
  assign fix_hi = (step1[DW-1:NIB] > DIG_MAX) | step1[DW] | cy_i;
  assign step2  = {1'b0, step1[DW-1:0]} + (fix_hi ? FIX_HI : '0);

  assign res_o = step2[DW-1:0];
  assign cy_o  = cy_i | step1[DW] | step2[DW];
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] opnd_res_o,
  output logic          cy_o
);
  always_comb begin
    res_o      = a_i;
    opnd_res_o = b_i;
    cy_o       = cy_i;
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_INC:  res_o = a_i + DW'(1);
      OP_DEC:  res_o = a_i - DW'(1);
      OP_CPL:  res_o = ~a_i;
      OP_CLR:  res_o = '0;
      OP_RL:   res_o = {a_i[DW-2:0], a_i[DW-1]};
      OP_RR:   res_o = {a_i[0], a_i[DW-1:1]};
      OP_RLC: begin
        res_o = {a_i[DW-2:0], cy_i};
        cy_o  = a_i[DW-1];
      end
      OP_RRC: begin
        res_o = {cy_i, a_i[DW-1:1]};
        cy_o  = a_i[0];
      end
      OP_SWAP: res_o = {a_i[NIB-1:0], a_i[DW-1:NIB]};
      OP_XCHD: begin
        res_o      = {a_i[DW-1:NIB], b_i[NIB-1:0]};
        opnd_res_o = {b_i[DW-1:NIB], a_i[NIB-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   opnd_i,
  input  logic            bit_i,
  output logic [DW-1:0]   result_o,
  output logic [DW-1:0]   opnd_o,
  output logic            cy_o,
  output logic            ac_o,
  output logic            ov_o
);
  alu_op_e    op;
  alu_flags_t flg_q, flg_d;
  logic [DW-1:0] res_d, opnd_d;

  logic [DW-1:0] as_res;
  logic          as_cy, as_ac, as_ov, as_sub, as_cin;
  logic [DW-1:0] da_res;
  logic          da_cy;
  logic [DW-1:0] bo_res, bo_opnd;
  logic          bo_cy;

  assign op     = alu_op_e'(op_i);
  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 : flg_q.cy;

  acc_alu_addsub u_addsub (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  acc_alu_dadj u_dadj (
    .a_i(acc_i), .cy_i(flg_q.cy), .ac_i(flg_q.ac),
    .res_o(da_res), .cy_o(da_cy)
  );

  acc_alu_bitops u_bitops (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(flg_q.cy),
    .res_o(bo_res), .opnd_res_o(bo_opnd), .cy_o(bo_cy)
  );

  always_comb begin
    flg_d  = flg_q;
    res_d  = bo_res;
    opnd_d = bo_opnd;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res_d = as_res;
        flg_d = '{cy: as_cy, ac: as_ac, ov: as_ov};
      end
      OP_DA: begin
        res_d    = da_res;
        flg_d.cy = da_cy;
      end
      OP_RLC, OP_RRC: flg_d.cy = bo_cy;
      OP_CAND: flg_d.cy = flg_q.cy & bit_i;
      OP_COR:  flg_d.cy = flg_q.cy | bit_i;
      OP_CCLR: flg_d.cy = 1'b0;
      OP_CSET: flg_d.cy = 1'b1;
      OP_CCPL: flg_d.cy = ~flg_q.cy;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q    <= '0;
      result_o <= '0;
      opnd_o   <= '0;
    end else if (we_i) begin
      flg_q    <= flg_d;
      result_o <= res_d;
      opnd_o   <= opnd_d;
    end
  end

  assign cy_o = flg_q.cy;
  assign ac_o = flg_q.ac;
  assign ov_o = flg_q.ov;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [OP_W-1:0] op_i,
  input logic [DW-1:0]   acc_i,
  input logic [DW-1:0]   opnd_i,
  input logic            bit_i,
  input logic [DW-1:0]   result_o,
  input logic [DW-1:0]   opnd_o,
  input logic            cy_o,
  input logic            ac_o,
  input logic            ov_o
);
  logic do_inc, do_da, do_rlc, do_xchd, do_cbit;
  assign do_inc  = we_i && (op_i == OP_INC || op_i == OP_DEC);
  assign do_da   = we_i && (op_i == OP_DA);
  assign do_rlc  = we_i && (op_i == OP_RLC);
  assign do_xchd = we_i && (op_i == OP_XCHD);
  assign do_cbit = we_i && (op_i == OP_CAND || op_i == OP_COR);

  AST_HOLD_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(result_o) && $stable(opnd_o) && $stable({cy_o, ac_o, ov_o})); // R1

  AST_INCDEC_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_inc |=> $stable({cy_o, ac_o, ov_o})); // R4

  AST_RLC_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_rlc |=> cy_o == $past(acc_i[DW-1]) && result_o[0] == $past(cy_o)); // R7

  AST_XCHD_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_xchd |=> result_o[DW-1:NIB] == $past(acc_i[DW-1:NIB])
             && opnd_o[DW-1:NIB] == $past(opnd_i[DW-1:NIB])); // R9

  AST_DA_CY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_da && cy_o |=> cy_o); // R10

  AST_DA_OV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_da |=> $stable(ov_o) && $stable(ac_o)); // R10

  AST_CBIT_OV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_cbit |=> $stable(ov_o) && $stable(ac_o)); // R11

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_ZERO: assert (result_o == '0 && opnd_o == '0 && !cy_o && !ac_o && !ov_o); // R12
    end
  end
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .op_i(op_i), .acc_i(acc_i),
  .opnd_i(opnd_i), .bit_i(bit_i), .result_o(result_o), .opnd_o(opnd_o),
  .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  import acc_alu_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc = '0, opnd = '0;
  logic bt = 1'b0;
  logic [7:0] result, opnd_r;
  logic cy, ac, ov;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  acc_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .op_i(op), .acc_i(acc),
    .opnd_i(opnd), .bit_i(bt), .result_o(result), .opnd_o(opnd_r),
    .cy_o(cy), .ac_o(ac), .ov_o(ov)
  );

  typedef struct packed {
    logic [7:0] res;
    logic [7:0] opn;
    logic cy, ac, ov;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic  m_cy = 0, m_ac = 0, m_ov = 0;
  exp_t  last;

  task automatic chk(string tag, string what, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, expv);
    end
  endtask

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic run(input alu_op_e o, input int a, input int b, input logic bi, input string tag);
    int r, t, c;
    exp_t e;
    r = a; e.opn = b[7:0];
    c = m_cy ? 1 : 0;
    case (o)
      OP_ADD, OP_ADDC: begin
        if (o == OP_ADD) c = 0;
        r = a + b + c;
        m_cy = (r > 255);
        m_ac = ((a % 16) + (b % 16) + c) > 15;
        t = sgn(a) + sgn(b) + c;
        m_ov = (t > 127) || (t < -128);
      end
      OP_SUBB: begin
        r = a - b - c;
        m_cy = (r < 0);
        m_ac = ((a % 16) - (b % 16) - c) < 0;
        t = sgn(a) - sgn(b) - c;
        m_ov = (t > 127) || (t < -128);
      end
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_INC:  r = a + 1;
      OP_DEC:  r = a + 255;
      OP_CPL:  r = 255 - a;
      OP_CLR:  r = 0;
      OP_RL:   r = (a * 2) + (a / 128);
      OP_RR:   r = (a / 2) + (a % 2) * 128;
      OP_RLC:  begin r = (a * 2) + c; m_cy = a >= 128; end
      OP_RRC:  begin r = (a / 2) + c * 128; m_cy = (a % 2) == 1; end
      OP_SWAP: r = (a % 16) * 16 + a / 16;
      OP_XCHD: begin
        r = (a / 16) * 16 + (b % 16);
        e.opn = 8'(((b / 16) * 16) + (a % 16));
      end
      OP_DA: begin
        r = a;
        if ((a % 16) > 9 || m_ac) r = r + 6;
        if (r > 255) m_cy = 1;
        r = r % 256;
        if ((r / 16) > 9 || m_cy) r = r + 96;
        if (r > 255) m_cy = 1;
      end
      OP_CAND: m_cy = m_cy & bi;
      OP_COR:  m_cy = m_cy | bi;
      OP_CCLR: m_cy = 0;
      OP_CSET: m_cy = 1;
      OP_CCPL: m_cy = ~m_cy;
      default: ;
    endcase
    e.res = 8'(r % 256);
    e.cy = m_cy; e.ac = m_ac; e.ov = m_ov;
    last = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    we = 1'b1; op = o; acc = a[7:0]; opnd = b[7:0]; bt = bi;
  endtask

  task automatic idle_hold(input string tag);
    @(negedge clk);
    we = 1'b0; op = OP_CLR; acc = 8'h5A; opnd = 8'hA5; bt = 1'b1;
    repeat (3) @(negedge clk);
    chk(tag, "hold result", result, last.res);
    chk(tag, "hold opnd", opnd_r, last.opn);
    chk(tag, "hold flags", {cy, ac, ov}, {last.cy, last.ac, last.ov});
  endtask

  initial begin : monitor
    logic w;
    exp_t e;
    string tg;
    forever begin
      @(posedge clk);
      w = we;
      @(negedge clk);
      if (w && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(tg, "result", result, e.res);
        chk(tg, "opnd", opnd_r, e.opn);
        chk(tg, "cy", cy, e.cy);
        chk(tg, "ac", ac, e.ac);
        chk(tg, "ov", ov, e.ov);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R12", "reset result", result, 0);
    chk("R12", "reset flags", {cy, ac, ov, opnd_r}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 add and carry use
    run(OP_ADD,  8'h3A, 8'hC6, 0, "R2");
    run(OP_ADD,  8'h7F, 8'h01, 0, "R2");
    run(OP_CSET, 8'h11, 8'h00, 0, "R11");
    run(OP_ADD,  8'h01, 8'h01, 0, "R2");
    run(OP_CSET, 8'h00, 8'h00, 0, "R11");
    run(OP_ADDC, 8'h10, 8'h20, 0, "R2");
    run(OP_ADD,  8'h80, 8'h80, 0, "R2");
    // R3 subtract
    run(OP_CCLR, 8'h00, 8'h00, 0, "R11");
    run(OP_SUBB, 8'h80, 8'h01, 0, "R3");
    run(OP_SUBB, 8'h00, 8'h01, 0, "R3");
    run(OP_SUBB, 8'h50, 8'h20, 0, "R3");
    run(OP_SUBB, 8'h7F, 8'hFF, 0, "R3");
    // R4 wrap, flags held
    run(OP_ADD,  8'h7F, 8'h01, 0, "R2");
    run(OP_INC,  8'hFF, 8'h00, 0, "R4");
    run(OP_DEC,  8'h00, 8'h00, 0, "R4");
    // R5 logic
    run(OP_AND,  8'hF0, 8'h3C, 0, "R5");
    run(OP_OR,   8'hF0, 8'h3C, 0, "R5");
    run(OP_XOR,  8'hF0, 8'h3C, 0, "R5");
    run(OP_CPL,  8'h96, 8'h00, 0, "R5");
    run(OP_CLR,  8'h96, 8'h00, 0, "R5");
    // R6 / R7 rotates
    run(OP_RL,   8'h81, 8'h00, 0, "R6");
    run(OP_RR,   8'h81, 8'h00, 0, "R6");
    run(OP_CCLR, 8'h00, 8'h00, 0, "R11");
    run(OP_RLC,  8'h81, 8'h00, 0, "R7");
    run(OP_RLC,  8'h02, 8'h00, 0, "R7");
    run(OP_RRC,  8'h01, 8'h00, 0, "R7");
    run(OP_RRC,  8'h40, 8'h00, 0, "R7");
    // R8 / R9
    run(OP_SWAP, 8'hA5, 8'h00, 0, "R8");
    run(OP_XCHD, 8'h12, 8'hAB, 0, "R9");
    run(OP_AND,  8'h12, 8'hC3, 0, "R9");
    // R10 decimal adjust
    run(OP_ADD,  8'h49, 8'h38, 0, "R2");
    run(OP_DA,   8'h81, 8'h00, 0, "R10");
    run(OP_ADD,  8'h99, 8'h99, 0, "R2");
    run(OP_DA,   8'h32, 8'h00, 0, "R10");
    run(OP_ADD,  8'h50, 8'h50, 0, "R2");
    run(OP_DA,   8'hA0, 8'h00, 0, "R10");
    run(OP_CCLR, 8'h00, 8'h00, 0, "R11");
    run(OP_DA,   8'h9A, 8'h00, 0, "R10");
    run(OP_CCLR, 8'h00, 8'h00, 0, "R11");
    run(OP_ADD,  8'h00, 8'h00, 0, "R2");
    run(OP_DA,   8'h45, 8'h00, 0, "R10");
    // R11 carry-bit ops with OV set
    run(OP_ADD,  8'h7F, 8'h01, 0, "R2");
    run(OP_CSET, 8'h33, 8'h00, 0, "R11");
    run(OP_CAND, 8'h33, 8'h00, 0, "R11");
    run(OP_COR,  8'h33, 8'h00, 1, "R11");
    run(OP_CAND, 8'h33, 8'h00, 1, "R11");
    run(OP_CCPL, 8'h33, 8'h00, 0, "R11");
    run(OP_CCPL, 8'h33, 8'h00, 0, "R11");
    // R1 hold with enable low
    idle_hold("R1");
    run(OP_INC,  8'h10, 8'h22, 0, "R1");
    idle_hold("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule